// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is an 8-bit arithmetic and logic unit that keeps its own 8-bit status register. Each cycle with `op_valid` high it reads two operands, a carry-in and a 4-bit opcode. It registers the result and updates the status register. Each opcode gives each flag one of four treatments: recomputed from the result, forced to 0, forced to 1, or left alone.

The status register holds, from bit 7 down to bit 0: interrupt enable (I), bit store (T), half carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C). Two further opcodes set or clear any single status bit, selected by an index on `b[2:0]`. A surrounding core drives one operation per valid cycle. It reads `result` when `res_we` pulses and reads `status` at any time.

Opcodes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 negate, 10 increment, 11 decrement, 12 set flag, 13 clear flag, 14 and 15 no operation.

Top module: `alu8_flags`

## Requirements
- R1: After reset, `status`, `result` and `res_we` are all 0.
- R2: Opcodes 0 (a+b) and 1 (a+b+carry_in) write the 8-bit sum one cycle later. They set status bit 0 (C) on a carry out of bit 7, bit 5 (H) on a carry from bit 3 into bit 4, and bit 3 (V) when two same-sign operands give a result of the other sign.
- R3: Opcodes 2 (a-b) and 3 (a-b-carry_in) write the difference. C is set on a borrow out of bit 7 and H on a borrow out of bit 3. V is set when operands of different sign give a result whose sign differs from a.
- R4: After every opcode 0 to 11, status bit 4 (S) equals N XOR V.
- R5: After every opcode 0 to 11, status bit 2 (N) equals bit 7 of the computed value, and status bit 1 (Z) is set exactly when that value is zero.
- R6: Opcodes 5 (AND), 6 (OR) and 7 (XOR) write a op b. They force V to 0 and leave C and H unchanged.
- R7: Opcode 8 writes ~a, forces C to 1 and V to 0, and leaves H unchanged. Opcode 9 writes 0-a, with flags as for subtracting a from zero.
- R8: Opcode 10 writes a+1 and opcode 11 writes a-1. V is set only for 0x7F→0x80 (increment) or 0x80→0x7F (decrement). C and H are unchanged.
- R9: Opcode 4 (compare) updates the flags exactly as opcode 2 does. It leaves `result` unchanged and keeps `res_we` at 0.
- R10: Opcode 12 sets and opcode 13 clears the status bit indexed by `b[2:0]` (7=I, 6=T, 5=H, 4=S, 3=V, 2=N, 1=Z, 0=C). All other status bits and `result` stay unchanged, and `res_we` stays 0.
- R11: Opcodes 0 to 11 never change I or T. Opcodes 14 and 15, and cycles with `op_valid` low, change nothing and leave `res_we` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform `op` this cycle |
| op | input | 4 | Opcode |
| a | input | 8 | First operand |
| b | input | 8 | Second operand, or flag index for opcodes 12/13 |
| carry_in | input | 1 | Carry or borrow in for opcodes 1 and 3 |
| result | output | 8 | Last written result |
| res_we | output | 1 | Pulses for one cycle when `result` was just written |
| status | output | 8 | Status register I,T,H,S,V,N,Z,C (bit 7..0) |

## Verification
The assertions assume that `op`, `a` and `b` are known whenever `op_valid` is high. They also assume that no opcode is read on a cycle with `op_valid` low. The `$past` checks on the flag index and on the held C and H bits depend on this. The stimulus changes inputs only at the falling edge and drops `op_valid` between operations. It draws opcodes from all sixteen codes, including the two no-ops, and draws operands over the full byte range. Directed cases cover the sign boundaries 0x7F/0x80, zero, and carry/borrow through bit 3 and bit 7.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       carry_in,
  output logic [7:0] result,
  output logic       res_we,
  output logic [7:0] status
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7;
  localparam logic [3:0] OP_COM = 4'd8,  OP_NEG = 4'd9,  OP_INC = 4'd10, OP_DEC = 4'd11;
  localparam logic [3:0] OP_FSET = 4'd12, OP_FCLR = 4'd13;

  localparam logic [1:0] M_KEEP = 2'd0, M_UPD = 2'd1, M_CLR = 2'd2, M_SET = 2'd3;

  function automatic logic apply(input logic [1:0] mode, input logic fresh, input logic old);
    case (mode)
      M_UPD:   return fresh;
      M_CLR:   return 1'b0;
      M_SET:   return 1'b1;
      default: return old;
    endcase
  endfunction

  logic [7:0] x, y;
  logic       ci;
  logic [8:0] sum9, dif9;

  assign x    = (op == OP_NEG) ? 8'h00 : a;
  assign y    = (op == OP_NEG) ? a : b;
  assign ci   = (op == OP_ADC || op == OP_SBC) ? carry_in : 1'b0;
  assign sum9 = {1'b0, x} + {1'b0, y} + {8'b0, ci};
  assign dif9 = {1'b0, x} - {1'b0, y} - {8'b0, ci};

  logic [7:0] r;
  logic       wr, rc, rh, rv;
  logic [1:0] mc, mh, mv, mnz;

  always_comb begin
    r = result; wr = 1'b0;
    rc = 1'b0; rh = 1'b0; rv = 1'b0;
    mc = M_KEEP; mh = M_KEEP; mv = M_KEEP; mnz = M_KEEP;
    case (op)
      OP_ADD, OP_ADC: begin
        r = sum9[7:0]; wr = 1'b1;
        mc = M_UPD; mh = M_UPD; mv = M_UPD; mnz = M_UPD;
        rc = sum9[8];
        rh = (x[3] & y[3]) | (y[3] & ~r[3]) | (~r[3] & x[3]);
        rv = (x[7] == y[7]) && (r[7] != x[7]);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        r = dif9[7:0]; wr = (op != OP_CMP);
        mc = M_UPD; mh = M_UPD; mv = M_UPD; mnz = M_UPD;
        rc = dif9[8];
        rh = (~x[3] & y[3]) | (y[3] & r[3]) | (r[3] & ~x[3]);
        rv = (x[7] != y[7]) && (r[7] != x[7]);
      end
      OP_AND: begin r = a & b; wr = 1'b1; mv = M_CLR; mnz = M_UPD; end
      OP_OR:  begin r = a | b; wr = 1'b1; mv = M_CLR; mnz = M_UPD; end
      OP_XOR: begin r = a ^ b; wr = 1'b1; mv = M_CLR; mnz = M_UPD; end
      OP_COM: begin r = ~a; wr = 1'b1; mc = M_SET; mv = M_CLR; mnz = M_UPD; end
      OP_INC: begin
        r = a + 8'd1; wr = 1'b1; mv = M_UPD; mnz = M_UPD;
        rv = (a == 8'h7F);
      end
      OP_DEC: begin
        r = a - 8'd1; wr = 1'b1; mv = M_UPD; mnz = M_UPD;
        rv = (a == 8'h80);
      end
      default: ;
    endcase
  end

  logic nc, nh, nv, nn, nz, ns;
  assign nc = apply(mc, rc, status[0]);
  assign nh = apply(mh, rh, status[5]);
  assign nv = apply(mv, rv, status[3]);
  assign nn = apply(mnz, r[7], status[2]);
  assign nz = apply(mnz, (r == 8'h00), status[1]);
  assign ns = (mnz == M_UPD) ? (nn ^ nv) : status[4];

  logic [7:0] alu_next, flag_next;
  assign alu_next = {status[7:6], nh, ns, nv, nn, nz, nc};

  always_comb begin
    flag_next = status;
    flag_next[b[2:0]] = (op == OP_FSET);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 8'h00;
      result <= 8'h00;
      res_we <= 1'b0;
    end else begin
      res_we <= 1'b0;
      if (op_valid) begin
        if (op <= OP_DEC) begin
          status <= alu_next;
          res_we <= wr;
          if (wr) result <= r;
        end else if (op == OP_FSET || op == OP_FCLR) begin
          status <= flag_next;
        end
      end
    end
  end

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op <= OP_DEC) |=> status[4] == (status[2] ^ status[3]));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> status[1] == (result == 8'h00));

  p_logic_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> !status[3] && status[0] == $past(status[0]) && status[5] == $past(status[5]));

  p_cmp_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CMP) |=> !res_we && $stable(result));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_FSET) |=> status[$past(b[2:0])] && !res_we);

  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_FCLR) |=> !status[$past(b[2:0])] && !res_we);

  p_it_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op <= OP_DEC) |=> status[7:6] == $past(status[7:6]));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status) && $stable(result) && !res_we);
endmodule

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'h00, b = 8'h00;
  logic       carry_in = 1'b0;
  logic [7:0] result, status;
  logic       res_we;

  int checks = 0, failures = 0;
  logic [7:0] m_st = 8'h00, m_res = 8'h00;

  alu8_flags dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .a(a), .b(b),
    .carry_in(carry_in), .result(result), .res_we(res_we), .status(status)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:             return "R2";
      4'd2, 4'd3:             return "R3";
      4'd4:                   return "R9";
      4'd5, 4'd6, 4'd7:       return "R6";
      4'd8, 4'd9:             return "R7";
      4'd10, 4'd11:           return "R8";
      4'd12, 4'd13:           return "R10";
      default:                return "R11";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [7:0] x0, input logic [7:0] y0,
                       input logic ci0, output logic we);
    int x, y, ci, d;
    logic [7:0] rr;
    logic c, h, v, n, z, alu;
    c = m_st[0]; h = m_st[5]; v = m_st[3];
    alu = 1'b1; we = 1'b1; rr = m_res;
    case (o)
      4'd0, 4'd1: begin
        ci = (o == 4'd1) ? int'(ci0) : 0;
        d = int'(x0) + int'(y0) + ci;
        rr = d[7:0]; c = (d > 255);
        h = ((int'(x0) % 16) + (int'(y0) % 16) + ci) > 15;
        v = (x0[7] == y0[7]) && (rr[7] != x0[7]);
      end
      4'd2, 4'd3, 4'd4, 4'd9: begin
        x = (o == 4'd9) ? 0 : int'(x0);
        y = (o == 4'd9) ? int'(x0) : int'(y0);
        ci = (o == 4'd3) ? int'(ci0) : 0;
        d = x - y - ci;
        rr = d[7:0]; c = (d < 0);
        h = ((x % 16) - (y % 16) - ci) < 0;
        v = ((x >= 128) != (y >= 128)) && (rr[7] != (x >= 128));
        we = (o != 4'd4);
      end
      4'd5: begin rr = x0 & y0; v = 1'b0; end
      4'd6: begin rr = x0 | y0; v = 1'b0; end
      4'd7: begin rr = x0 ^ y0; v = 1'b0; end
      4'd8: begin rr = ~x0; c = 1'b1; v = 1'b0; end
      4'd10: begin rr = x0 + 8'd1; v = (x0 == 8'h7F); end
      4'd11: begin rr = x0 - 8'd1; v = (x0 == 8'h80); end
      4'd12, 4'd13: begin alu = 1'b0; we = 1'b0; m_st[y0[2:0]] = (o == 4'd12); end
      default: begin alu = 1'b0; we = 1'b0; end
    endcase
    if (alu) begin
      n = rr[7]; z = (rr == 8'h00);
      m_st = {m_st[7:6], h, n ^ v, v, n, z, c};
      if (we) m_res = rr;
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] x0, input logic [7:0] y0,
                      input logic ci0);
    logic we_e;
    logic [7:0] it_before;
    string t;
    t = tag_of(o);
    it_before = m_st;
    model(o, x0, y0, ci0, we_e);
    @(negedge clk);
    op = o; a = x0; b = y0; carry_in = ci0; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(t, {7'b0, res_we, status, 8'h00, result}, {7'b0, we_e, m_st, 8'h00, m_res});
    if (o <= 4'd11) begin
      check("R4", {31'b0, status[4]}, {31'b0, status[2] ^ status[3]});
      if (o != 4'd4) check("R5", {31'b0, status[1]}, {31'b0, result == 8'h00});
      check("R11", {30'b0, status[7:6]}, {30'b0, it_before[7:6]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", {15'b0, res_we, status, result}, 32'h0);
    rst_n = 1'b1;

    step(4'd0, 8'h7F, 8'h01, 1'b0);   // R2 overflow and half carry
    step(4'd0, 8'hFF, 8'h01, 1'b0);   // R2 carry out, zero
    step(4'd1, 8'h0F, 8'h00, 1'b1);   // R2 carry-in into bit 4
    step(4'd2, 8'h00, 8'h01, 1'b0);   // R3 borrow
    step(4'd2, 8'h80, 8'h01, 1'b0);   // R3 overflow
    step(4'd3, 8'h10, 8'h0F, 1'b1);   // R3 borrow-in gives zero
    step(4'd4, 8'h33, 8'h33, 1'b0);   // R9 equal compare
    step(4'd4, 8'h01, 8'h02, 1'b0);   // R9 borrow compare
    step(4'd12, 8'h00, 8'h00, 1'b0);  // R10 set C
    step(4'd12, 8'h00, 8'h05, 1'b0);  // R10 set H
    step(4'd5, 8'hF0, 8'h0F, 1'b0);   // R6 AND zero, C and H kept
    step(4'd6, 8'h80, 8'h01, 1'b0);   // R6 OR negative
    step(4'd7, 8'hAA, 8'hAA, 1'b0);   // R6 XOR zero
    step(4'd13, 8'h00, 8'h00, 1'b0);  // R10 clear C
    step(4'd8, 8'h00, 8'h00, 1'b0);   // R7 complement forces C
    step(4'd9, 8'h00, 8'h00, 1'b0);   // R7 negate zero
    step(4'd9, 8'h80, 8'h00, 1'b0);   // R7 negate 0x80
    step(4'd9, 8'h01, 8'h00, 1'b0);   // R7 negate one
    step(4'd10, 8'h7F, 8'h00, 1'b0);  // R8 increment overflow
    step(4'd11, 8'h80, 8'h00, 1'b0);  // R8 decrement overflow
    step(4'd11, 8'h00, 8'h00, 1'b0);  // R8 decrement wrap, C kept
    step(4'd12, 8'h00, 8'h07, 1'b0);  // R10 set I
    step(4'd12, 8'h00, 8'h06, 1'b0);  // R10 set T
    step(4'd0, 8'h01, 8'h01, 1'b0);   // R11 I and T kept
    step(4'd12, 8'h00, 8'h04, 1'b0);  // R10 set S alone
    step(4'd14, 8'h55, 8'h55, 1'b1);  // R11 no-op
    step(4'd15, 8'hAA, 8'h03, 1'b1);  // R11 no-op
    step(4'd13, 8'h00, 8'h07, 1'b0);  // R10 clear I

    repeat (4) @(negedge clk);
    check("R11", {15'b0, res_we, status, result}, {15'b0, 1'b0, m_st, m_res});

    for (int i = 0; i < 3000; i++) begin
      step(4'($urandom % 16), 8'($urandom), 8'($urandom), 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule